// File: doc/BRIEF.md
# NAND Strobe-Latch Update Sequencer

This block drives a NAND flash whose control strobes do not come straight from the controller. A plain write bus loads a mode register with the wanted strobe levels: command-latch, address-latch, a two-bit chip select, write-enable and chip-enable. Only chip-enable reaches its pin at once. The other strobes sit behind an external holding latch, modelled at the block's outputs. They move to the pins only when that latch is loaded.

Any write to the data address runs one timed external bus cycle. The cycle has two setup cycles, then a latch-load pulse of programmable width, then a programmable hold, then two recovery cycles. During the pulse the block drives the written data onto the flash data bus, and the latch takes the strobe levels that were in the mode register when the write was accepted. Software can issue back-to-back data writes as a hardware-timed wait, because each one costs a known number of clocks. A write of any value to the reset address returns the whole block to its power-up state, and it aborts a cycle that is in flight.

The write bus is a valid/ready channel. A beat transfers on a clock edge where `wr_valid` and `wr_ready` are both high. The address, data and valid signals must stay steady until that edge. While a bus cycle is running, `wr_ready` is low for every address except the reset address, so timing, mode and data writes wait until the cycle ends. A reset write is always accepted.

Top module: `nand_latch_upd`

## Requirements
- R1: A write of any value to address 0 (reset) clears the mode register, sets the timing register back to its default, drives all latched strobes to 0, drops `busy` and aborts any cycle in flight. All of this is visible on the cycle after the write is accepted.
- R2: After `rst_n` the block is idle. `busy`, `nd_ce`, every latched strobe, `nd_latch_ld` and `nd_dq_oe` are 0, and the timing register holds a pulse of 1 and a hold of 0.
- R3: The bus addresses are 1 for timing, 2 for mode and 3 for data. The mode register bits are: bit 0 command-latch, bit 1 address-latch, bits 3:2 chip select, bit 4 chip-enable, bit 7 write-enable and bit 8 wide (16-bit) data.
- R4: `nd_ce` equals mode bit 4 from the cycle after a mode write is accepted, whether or not a bus cycle runs.
- R5: The latched outputs `nd_we`, `nd_cs`, `nd_ale` and `nd_cle` change only at the clock edge that ends the latch-load pulse (or at a reset write). They take the mode-register values that were in force when the data write was accepted.
- R6: A data write holds `busy` high for exactly pulse + hold + 4 clock cycles, starting on the cycle after acceptance.
- R7: In the timing register the pulse width is held in bits 3:0 and the hold count in bits 11:8. A pulse field of 0 acts as 1, so the value 0x0106 gives a pulse of 6 and a hold of 1.
- R8: `nd_latch_ld` is high for exactly the pulse width. It rises on the third busy cycle, after two setup cycles.
- R9: `nd_dq_oe` is high exactly while `nd_latch_ld` is high, and `nd_dq_o` then shows the written data. With wide mode set all 16 bits are driven. With wide mode clear, the low byte is driven and the upper byte is 0.
- R10: While `busy` is high, `wr_ready` is low for addresses 1 to 3 and high for address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write beat valid |
| wr_ready | output | 1 | Write beat accepted this edge if valid |
| wr_addr | input | 2 | Register address: 0 reset, 1 timing, 2 mode, 3 data |
| wr_data | input | 16 | Write data |
| nd_ce | output | 1 | Flash chip-enable, driven directly from the mode register |
| nd_we | output | 1 | Latched write-enable |
| nd_cs | output | 2 | Latched chip select |
| nd_ale | output | 1 | Latched address-latch enable |
| nd_cle | output | 1 | Latched command-latch enable |
| nd_latch_ld | output | 1 | Load strobe to the external latch |
| nd_dq_o | output | 16 | Flash data bus output |
| nd_dq_oe | output | 1 | Flash data bus output enable |
| busy | output | 1 | External bus cycle in progress |

## Verification
The assertions assume that the write channel follows the valid/ready rule: address and data stay steady while `wr_valid` waits for `wr_ready`. They also assume that only one beat is offered at a time, so a reset write never coincides with another write. The bench drives one beat at a time from a single task, changes inputs only at falling edges, and holds each beat until the falling edge that follows acceptance. Back-pressure is exercised by offering a data write while a cycle runs and observing `wr_ready` low. The in-flight abort is exercised by a reset write during the hold phase.

// File: rtl/nfl_pkg.sv
package nfl_pkg;
  // register addresses
  localparam logic [1:0] A_RST  = 2'd0;
  localparam logic [1:0] A_TIME = 2'd1;
  localparam logic [1:0] A_MODE = 2'd2;
  localparam logic [1:0] A_DATA = 2'd3;

  // mode register bit positions
  localparam int B_CLE  = 0;
  localparam int B_ALE  = 1;
  localparam int B_CS0  = 2;
  localparam int B_CE   = 4;
  localparam int B_WE   = 7;
  localparam int B_WIDE = 8;

  // fixed overhead split around the pulse/hold window (sum is 4)
  localparam int SETUP_CYC = 2;
  localparam int RECOV_CYC = 2;

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_PULSE, S_HOLD, S_RECOV
  } seq_st_t;

  typedef struct packed {
    logic       we;
    logic [1:0] cs;
    logic       ale;
    logic       cle;
  } strobe_t;
endpackage

// File: rtl/nfl_ctrl_regs.sv
module nfl_ctrl_regs
  import nfl_pkg::*;
#(
  parameter int DW       = 16,
  parameter int PW_W     = 4,
  parameter int HD_W     = 4,
  parameter int HOLD_LSB = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            soft_rst,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [DW-1:0]   wr_data,
  output strobe_t         strobes,
  output logic            ce,
  output logic            wide,
  output logic [PW_W-1:0] pulse_eff,
  output logic [HD_W-1:0] hold
);
  localparam logic [PW_W-1:0] PULSE_DEF = PW_W'(1);

  logic [PW_W-1:0] pulse_q;
  logic [HD_W-1:0] hold_q;
  strobe_t         str_q;
  logic            ce_q, wide_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= PULSE_DEF;
      hold_q  <= '0;
      str_q   <= '0;
      ce_q    <= 1'b0;
      wide_q  <= 1'b0;
    end else if (soft_rst) begin
      pulse_q <= PULSE_DEF;
      hold_q  <= '0;
      str_q   <= '0;
      ce_q    <= 1'b0;
      wide_q  <= 1'b0;
    end else if (wr_en) begin
      if (wr_addr == A_TIME) begin
        pulse_q <= wr_data[PW_W-1:0];
        hold_q  <= wr_data[HOLD_LSB +: HD_W];
      end
      if (wr_addr == A_MODE) begin
        str_q.cle <= wr_data[B_CLE];
        str_q.ale <= wr_data[B_ALE];
        str_q.cs  <= wr_data[B_CS0 +: 2];
        str_q.we  <= wr_data[B_WE];
        ce_q      <= wr_data[B_CE];
        wide_q    <= wr_data[B_WIDE];
      end
    end
  end

  assign strobes   = str_q;
  assign ce        = ce_q;
  assign wide      = wide_q;
  assign hold      = hold_q;
  assign pulse_eff = (pulse_q == '0) ? PULSE_DEF : pulse_q;
endmodule

// File: rtl/nfl_cycle_seq.sv
module nfl_cycle_seq
  import nfl_pkg::*;
#(
  parameter int DW   = 16,
  parameter int PW_W = 4,
  parameter int HD_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            soft_rst,
  input  logic            start,
  input  logic [PW_W-1:0] pulse_eff,
  input  logic [HD_W-1:0] hold,
  input  strobe_t         strobes,
  input  logic            wide,
  input  logic [DW-1:0]   wdata,
  output logic            busy,
  output logic            ld,
  output logic            cap,
  output strobe_t         snap,
  output logic [DW-1:0]   dq_o,
  output logic            dq_oe
);
  localparam int CW = (PW_W > HD_W) ? PW_W : HD_W;

  seq_st_t       st_q;
  logic [CW-1:0] cnt_q;
  strobe_t       snap_q;
  logic          wide_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      snap_q <= '0;
      wide_q <= 1'b0;
      data_q <= '0;
    end else if (soft_rst) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (start) begin
          st_q   <= S_SETUP;
          cnt_q  <= CW'(SETUP_CYC - 1);
          snap_q <= strobes;
          wide_q <= wide;
          data_q <= wdata;
        end
        S_SETUP: if (cnt_q == '0) begin
          st_q  <= S_PULSE;
          cnt_q <= CW'(pulse_eff - 1'b1);
        end else cnt_q <= cnt_q - 1'b1;
        S_PULSE: if (cnt_q == '0) begin
          if (hold == '0) begin
            st_q  <= S_RECOV;
            cnt_q <= CW'(RECOV_CYC - 1);
          end else begin
            st_q  <= S_HOLD;
            cnt_q <= CW'(hold - 1'b1);
          end
        end else cnt_q <= cnt_q - 1'b1;
        S_HOLD: if (cnt_q == '0) begin
          st_q  <= S_RECOV;
          cnt_q <= CW'(RECOV_CYC - 1);
        end else cnt_q <= cnt_q - 1'b1;
        S_RECOV: if (cnt_q == '0) st_q <= S_IDLE;
                 else cnt_q <= cnt_q - 1'b1;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy  = (st_q != S_IDLE);
  assign ld    = (st_q == S_PULSE);
  assign cap   = ld && (cnt_q == '0);
  assign snap  = snap_q;
  assign dq_oe = ld;
  assign dq_o  = !ld ? '0 :
                 wide_q ? data_q : {{(DW-8){1'b0}}, data_q[7:0]};

  // a cycle may only be launched from idle (R10 back-pressure)
  p_start_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (st_q == S_IDLE));

  // data bus steady across the whole pulse
  p_dq_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && $past(dq_oe)) |-> $stable(dq_o));
endmodule

// File: rtl/nfl_strobe_latch.sv
module nfl_strobe_latch
  import nfl_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    clr,
  input  logic    cap,
  input  strobe_t d,
  output strobe_t q
);
  strobe_t q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q_r <= '0;
    else if (clr) q_r <= '0;
    else if (cap) q_r <= d;
  end

  assign q = q_r;

  p_latch_on_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(q_r) |-> ($past(cap) || $past(clr)));
endmodule

// File: rtl/nand_latch_upd.sv
module nand_latch_upd
  import nfl_pkg::*;
#(
  parameter int DW       = 16,
  parameter int PW_W     = 4,
  parameter int HD_W     = 4,
  parameter int HOLD_LSB = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          nd_ce,
  output logic          nd_we,
  output logic [1:0]    nd_cs,
  output logic          nd_ale,
  output logic          nd_cle,
  output logic          nd_latch_ld,
  output logic [DW-1:0] nd_dq_o,
  output logic          nd_dq_oe,
  output logic          busy
);
  logic            acc, soft_rst, start, cap, ce, wide;
  strobe_t         strobes, snap, lq;
  logic [PW_W-1:0] pulse_eff;
  logic [HD_W-1:0] hold;

  assign wr_ready = !busy || (wr_addr == A_RST);
  assign acc      = wr_valid && wr_ready;
  assign soft_rst = acc && (wr_addr == A_RST);
  assign start    = acc && (wr_addr == A_DATA);

  nfl_ctrl_regs #(.DW(DW), .PW_W(PW_W), .HD_W(HD_W), .HOLD_LSB(HOLD_LSB)) u_regs (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(acc),
    .wr_addr(wr_addr), .wr_data(wr_data), .strobes(strobes), .ce(ce),
    .wide(wide), .pulse_eff(pulse_eff), .hold(hold));

  nfl_cycle_seq #(.DW(DW), .PW_W(PW_W), .HD_W(HD_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .start(start),
    .pulse_eff(pulse_eff), .hold(hold), .strobes(strobes), .wide(wide),
    .wdata(wr_data), .busy(busy), .ld(nd_latch_ld), .cap(cap), .snap(snap),
    .dq_o(nd_dq_o), .dq_oe(nd_dq_oe));

  nfl_strobe_latch u_latch (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .cap(cap), .d(snap), .q(lq));

  assign nd_ce  = ce;
  assign nd_we  = lq.we;
  assign nd_cs  = lq.cs;
  assign nd_ale = lq.ale;
  assign nd_cle = lq.cle;

  p_ce_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && wr_addr == A_MODE) |=> (nd_ce == $past(wr_data[B_CE])));

  p_reset_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!busy && !nd_ce && lq == '0 && !nd_latch_ld));

  p_ld_in_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    nd_latch_ld |-> busy);
endmodule

// File: tb/tb_nand_latch_upd.sv
module tb_nand_latch_upd;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    int          dur;
    int          pc;
    logic [15:0] dout;
    logic [4:0]  lat;
  } exp_t;

  logic        clk = 0, rst_n = 0, wr_valid = 0;
  logic [1:0]  wr_addr = 0;
  logic [15:0] wr_data = 0;
  logic        wr_ready, nd_ce, nd_we, nd_ale, nd_cle, nd_latch_ld, nd_dq_oe, busy;
  logic [1:0]  nd_cs;
  logic [15:0] nd_dq_o;

  int n_chk = 0, n_bad = 0;
  exp_t q[$];
  bit mon_en = 1;
  logic [4:0] lat_prev = 0;

  nand_latch_upd dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [4:0] lat_now();
    return {nd_we, nd_cs, nd_ale, nd_cle};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_valid = 1; wr_addr = a; wr_data = d;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 0;
  endtask

  // latch image of a mode word: {we, cs[1:0], ale, cle}
  function automatic logic [4:0] lat_of(input logic [15:0] m);
    return {m[7], m[3:2], m[1], m[0]};
  endfunction

  task automatic dw(input logic [15:0] d, input int p, input int h,
                    input logic [15:0] mode);
    exp_t e;
    e.dur  = p + h + 4;
    e.pc   = p;
    e.dout = mode[8] ? d : {8'h00, d[7:0]};
    e.lat  = lat_of(mode);
    q.push_back(e);
    wr(2'd3, d);
  endtask

  // monitor / scoreboard
  int bcnt = 0, lcnt = 0, lfirst = 0;
  logic [15:0] dseen = 0;
  bit dbad = 0;
  always @(negedge clk) if (mon_en && rst_n) begin
    if (busy) begin
      bcnt++;
      if (nd_latch_ld) begin
        lcnt++;
        if (lcnt == 1) begin lfirst = bcnt; dseen = nd_dq_o; end
        if (!nd_dq_oe || nd_dq_o != dseen) dbad = 1;
        check(lat_now() == lat_prev, "R5 latched held during pulse", lat_now(), lat_prev);
      end else if (nd_dq_oe) dbad = 1;
    end else if (bcnt != 0) begin
      exp_t e;
      if (q.size() == 0) check(0, "R6 unexpected cycle", bcnt, 0);
      else begin
        e = q.pop_front();
        check(bcnt == e.dur, "R6 busy length", bcnt, e.dur);
        check(lcnt == e.pc, "R8 load pulse width", lcnt, e.pc);
        check(lfirst == 3, "R8 load pulse position", lfirst, 3);
        check(dseen == e.dout && !dbad, "R9 data drive", dseen, e.dout);
        check(lat_now() == e.lat, "R5 latched after strobe", lat_now(), e.lat);
        lat_prev = e.lat;
      end
      bcnt = 0; lcnt = 0; dbad = 0;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!busy && !nd_ce && lat_now() == 0 && !nd_latch_ld && !nd_dq_oe,
          "R2 reset state", {busy, nd_ce, lat_now()}, 0);
    // R2 default timing pulse 1 hold 0, narrow drive
    dw(16'hA5C3, 1, 0, 16'h0000);
    wait (q.size() == 0); @(negedge clk);

    // R3 R7 timing 0x0106, mode: ce|cs=1|cle
    wr(2'd1, 16'h0106);
    wr(2'd2, 16'h0015);
    check(nd_ce == 1, "R4 ce immediate", nd_ce, 1);
    check(lat_now() == 0, "R5 latched unchanged by mode write", lat_now(), 0);
    dw(16'h1234, 6, 1, 16'h0015);
    wait (q.size() == 0); @(negedge clk);

    // wide mode, we, ce, ale, cs=2
    wr(2'd2, 16'h019A);
    dw(16'hBEEF, 6, 1, 16'h019A);
    // R4: ce follows even with a cycle idle/following
    wait (q.size() == 0); @(negedge clk);

    // back-to-back updates, pulse 2 hold 3
    wr(2'd1, 16'h0302);
    dw(16'h0001, 2, 3, 16'h019A);
    wr_valid = 1; wr_addr = 2'd3; wr_data = 16'h0002;
    #1 check(wr_ready == 0, "R10 stall while busy", wr_ready, 0);
    wr_addr = 2'd0;
    #1 check(wr_ready == 1, "R10 reset accepted while busy", wr_ready, 1);
    wr_valid = 0; wr_addr = 2'd3;
    for (int i = 0; i < 3; i++) dw(16'h0010 + 16'(i), 2, 3, 16'h019A);
    wait (q.size() == 0); @(negedge clk);

    // R7 pulse field 0 acts as 1; longest pulse
    wr(2'd2, 16'h0003);
    check(nd_ce == 0, "R4 ce cleared", nd_ce, 0);
    wr(2'd1, 16'h0000);
    dw(16'h7788, 1, 0, 16'h0003);
    wr(2'd1, 16'h020F);
    dw(16'h6655, 15, 2, 16'h0003);
    wait (q.size() == 0); @(negedge clk);

    // R1 soft reset while idle
    wr(2'd2, 16'h019A);
    wr(2'd0, 16'h1234);
    check(!nd_ce && lat_now() == 0 && !busy, "R1 soft reset idle",
          {nd_ce, lat_now()}, 0);
    lat_prev = 0;
    dw(16'h00FF, 1, 0, 16'h0000);
    wait (q.size() == 0); @(negedge clk);

    // R1 abort in flight
    wr(2'd1, 16'h0F0F);
    wr(2'd2, 16'h0095);
    mon_en = 0;
    wr(2'd3, 16'h4321);
    repeat (20) @(negedge clk);
    check(busy == 1, "R1 cycle running before abort", busy, 1);
    check(lat_now() == lat_of(16'h0095), "R5 latched after pulse", lat_now(), lat_of(16'h0095));
    wr(2'd0, 16'h0000);
    check(!busy && !nd_ce && lat_now() == 0 && !nd_dq_oe, "R1 abort clears",
          {busy, nd_ce, lat_now()}, 0);
    mon_en = 1; lat_prev = 0;
    dw(16'h0A0B, 1, 0, 16'h0000);
    wait (q.size() == 0); @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule